// File: doc/BRIEF.md
# Multi-Region I/O Wait-State Generator

This block carries core accesses into a separate 2048-word peripheral I/O space. For each accepted request it drives an external address, one read or write strobe and the write data. It holds the strobe long enough for slow peripherals. How long depends on which quarter of the I/O space is addressed. Each quarter has its own 3-bit wait field. A single mode bit applies to all four fields and makes each field count either directly or as an odd number (2N+1). The core sees a ready pulse, and on reads the returned data, in the final strobe cycle.

The wait fields and the mode bit live in a small configuration register. It is loaded as a whole by a one-cycle load pulse. After reset it selects the slowest normal timing. One access runs at a time. A request that arrives while an access is running is dropped, except in the ready cycle, where it starts the next access with no idle cycle between.

Top module: `iows_gen`

## Requirements
- R1: `io_addr[10:0]` equals the request address and `io_addr[13:11]` is 0 in every strobe cycle. The address stays unchanged for the whole access.
- R2: Address bits 10:9 select the region (0 is the lowest 512 words). Region i takes its wait count N from `cfg_waits[3*i+2:3*i]`.
- R3: With the mode bit at 0, the strobe is high for exactly N+1 consecutive cycles.
- R4: With the mode bit at 1, the strobe is high for exactly 2N+2 consecutive cycles, which is 2N+1 wait states.
- R5: The strobe rises in the cycle after the request is sampled. `core_ready` is high only in the final strobe cycle.
- R6: A write (`req_write`=1) raises only `io_wr` and drives `io_wdata` with the request data for the whole access. A read raises only `io_rd`.
- R7: On a read, `core_rdata` equals `io_rdata` in the ready cycle. After that it holds this value until the next read completes.
- R8: A request sampled during an access, in any cycle other than its final one, is ignored. The running access keeps its address, direction and length, and no extra access follows.
- R9: A request sampled in the ready cycle is accepted. Its strobe begins in the very next cycle.
- R10: After reset, no strobe or ready is active, every region wait field is 7 and the mode bit is 0. An access therefore lasts 8 strobe cycles.
- R11: A configuration load applies to requests sampled after the load edge. An access already running keeps the length it was given when it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load the wait fields and the mode bit |
| cfg_mode | input | 1 | Wait mode: 0 = N waits, 1 = 2N+1 waits |
| cfg_waits | input | 12 | Four 3-bit region wait fields, region 0 in bits 2:0 |
| req_valid | input | 1 | I/O request strobe from the core |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | I/O word address |
| req_wdata | input | 16 | Write data |
| io_addr | output | 14 | External address, upper 3 bits 0 |
| io_rd | output | 1 | External read strobe |
| io_wr | output | 1 | External write strobe |
| io_wdata | output | 16 | External write data |
| io_rdata | input | 16 | External read data |
| core_rdata | output | 16 | Read data returned to the core |
| core_ready | output | 1 | Access completes this cycle |

## Verification
A request sampled at edge k gives a strobe from cycle k+1 through cycle k+1+W, where W is the wait count. Ready and the read data are due in cycle k+1+W, and the held read data from cycle k+2+W onward. The bench drives inputs and samples outputs on falling edges. It checks strobe, address and data in every cycle of an access and compares the length with W+1, computed from the region fields and the mode. It also changes the bus read value every cycle, so that the captured word shows exactly which cycle the data was taken from.

// File: rtl/iows_pkg.sv
package iows_pkg;
  localparam int FIELD_W = 3;
  localparam int CNT_W   = FIELD_W + 1;

  // Wait states for one region field: N, or 2N+1 in odd mode.
  function automatic logic [CNT_W-1:0] iows_wait(input logic odd_mode,
                                                 input logic [FIELD_W-1:0] n);
    return odd_mode ? {n, 1'b1} : {1'b0, n};
  endfunction
endpackage

// File: rtl/iows_cfg.sv
module iows_cfg
  import iows_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    mode_in,
  input  logic [NREG*FIELD_W-1:0] waits_in,
  output logic                    mode_q,
  output logic [NREG*FIELD_W-1:0] waits_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     mode_q <= 1'b0;
    else if (load)  mode_q <= mode_in;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)     waits_q[g*FIELD_W +: FIELD_W] <= '1;
      else if (load)  waits_q[g*FIELD_W +: FIELD_W] <= waits_in[g*FIELD_W +: FIELD_W];
    end
  end
endmodule

// File: rtl/iows_region.sv
module iows_region
  import iows_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int NREG   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    mode,
  input  logic [NREG*FIELD_W-1:0] waits,
  output logic [CNT_W-1:0]        wait_cnt
);
  localparam int SEL_W = $clog2(NREG);

  logic [SEL_W-1:0] region;
  logic [CNT_W-1:0] per_region [NREG];

  assign region = addr[ADDR_W-1 -: SEL_W];

  for (genvar g = 0; g < NREG; g++) begin : g_wait
    assign per_region[g] = iows_wait(mode, waits[g*FIELD_W +: FIELD_W]);
  end

  assign wait_cnt = per_region[region];

  AST_NORMAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |-> wait_cnt <= CNT_W'(7)); // R3
  AST_ODD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    mode |-> wait_cnt[0]); // R4
endmodule

// File: rtl/iows_seq.sv
module iows_seq
  import iows_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] wait_cnt,
  output logic             accept,
  output logic             busy,
  output logic             last
);
  logic [CNT_W-1:0] remain;

  assign last   = busy && (remain == '0);
  assign accept = req_valid && (!busy || last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      remain <= wait_cnt;
    end else if (last) begin
      busy   <= 1'b0;
    end else if (busy) begin
      remain <= remain - {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  AST_DROP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> busy); // R8
endmodule

// File: rtl/iows_gen.sv
module iows_gen
  import iows_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int EXT_W  = 14,
  parameter int DATA_W = 16,
  parameter int NREG   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_load,
  input  logic                    cfg_mode,
  input  logic [NREG*FIELD_W-1:0] cfg_waits,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic [EXT_W-1:0]        io_addr,
  output logic                    io_rd,
  output logic                    io_wr,
  output logic [DATA_W-1:0]       io_wdata,
  input  logic [DATA_W-1:0]       io_rdata,
  output logic [DATA_W-1:0]       core_rdata,
  output logic                    core_ready
);
  localparam int PAD_W = EXT_W - ADDR_W;

  logic                    mode_q;
  logic [NREG*FIELD_W-1:0] waits_q;
  logic [CNT_W-1:0]        wait_cnt;
  logic                    accept, busy, last;
  logic [ADDR_W-1:0]       addr_q;
  logic [DATA_W-1:0]       wdata_q, rdata_q;
  logic                    write_q;
  logic                    read_done;

  iows_cfg #(.NREG(NREG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .mode_in(cfg_mode),
    .waits_in(cfg_waits), .mode_q(mode_q), .waits_q(waits_q)
  );

  iows_region #(.ADDR_W(ADDR_W), .NREG(NREG)) u_region (
    .clk(clk), .rst_n(rst_n), .addr(req_addr), .mode(mode_q),
    .waits(waits_q), .wait_cnt(wait_cnt)
  );

  iows_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .wait_cnt(wait_cnt),
    .accept(accept), .busy(busy), .last(last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
    end
  end

  assign read_done = last && !write_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         rdata_q <= '0;
    else if (read_done) rdata_q <= io_rdata;
  end

  assign io_addr    = {{PAD_W{1'b0}}, addr_q};
  assign io_rd      = busy && !write_q;
  assign io_wr      = busy && write_q;
  assign io_wdata   = wdata_q;
  assign core_ready = last;
  assign core_rdata = read_done ? io_rdata : rdata_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_wr)); // R6
  AST_READY_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    core_ready |-> (io_rd || io_wr)); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || io_wr) && !core_ready |=> $stable(io_addr) && (io_rd || io_wr)); // R1
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && !core_ready |=> $stable(io_wdata) && io_wr); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !core_ready |-> $stable(core_rdata)); // R7
endmodule

// File: tb/tb_iows_gen.sv
module tb_iows_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0, cfg_mode = 1'b0;
  logic [11:0] cfg_waits = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [10:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [13:0] io_addr;
  logic        io_rd, io_wr, core_ready;
  logic [15:0] io_wdata, core_rdata;
  logic [15:0] io_rdata = '0;

  int checks = 0, fails = 0;
  int bus_tick = 0;

  always #5 clk = ~clk;

  iows_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_waits(cfg_waits), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .io_addr(io_addr),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .core_rdata(core_rdata), .core_ready(core_ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_wait(input bit mode, input int n);
    return mode ? (n * 2 + 1) : n;
  endfunction

  // Called right after a falling edge: drive a request for one sampling edge.
  task automatic start_req(input bit w, input logic [10:0] a, input logic [15:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
  endtask

  task automatic load_cfg(input bit m, input logic [11:0] f);
    @(negedge clk);
    cfg_load = 1'b1; cfg_mode = m; cfg_waits = f;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // Follows one access whose request is already driven. stray>=0 drops an
  // extra request at that strobe cycle; chain starts the next access at ready.
  task automatic observe(input bit w, input logic [10:0] a, input logic [15:0] d,
                         input int expw, input int stray, input bit chain,
                         input bit nw, input logic [10:0] na, input logic [15:0] nd);
    int len = 0;
    bit done = 0;
    bit strobe_ok = 1;
    logic [15:0] got = '0;
    for (int k = 0; k < 40 && !done; k++) begin
      @(negedge clk);
      bus_tick++;
      io_rdata = 16'h3C5A ^ 16'(bus_tick * 16'h0101);
      if (k == stray) start_req(!w, a ^ 11'h600, ~d);
      else req_valid = 1'b0;
      #1;
      len++;
      if (!(w ? (io_wr && !io_rd) : (io_rd && !io_wr))) strobe_ok = 0;
      if (io_addr != {3'b000, a}) strobe_ok = 0;
      if (w && io_wdata != d) strobe_ok = 0;
      if (core_ready) begin
        done = 1;
        got = io_rdata;
        if (!w) chk(core_rdata == io_rdata, "R7 rdata at ready", core_rdata, io_rdata);
        if (chain) start_req(nw, na, nd);
      end
    end
    chk(strobe_ok, "R1/R6 strobe, addr, data every cycle", strobe_ok, 1);
    chk(len == expw + 1, "R2/R3/R4/R5 strobe length", len, expw + 1);
    if (!chain) begin
      @(negedge clk);
      bus_tick++;
      io_rdata = ~io_rdata;
      req_valid = 1'b0;
      #1;
      chk(!io_rd && !io_wr && !core_ready, "R8 idle after access",
          {io_rd, io_wr, core_ready}, 0);
      if (!w) chk(core_rdata == got, "R7 rdata held", core_rdata, got);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!io_rd && !io_wr && !core_ready, "R10 reset outputs", {io_rd, io_wr, core_ready}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: default fields 7, normal mode, in every region
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      start_req(r[0], {r[1:0], 9'h055}, 16'hA000 + 16'(r));
      observe(r[0], {r[1:0], 9'h055}, 16'hA000 + 16'(r), 7, -1, 0, 0, '0, '0);
    end

    // R2 R3 R4: sweep mode, field value, region and direction
    for (int m = 0; m < 2; m++) begin
      for (int n = 0; n < 8; n++) begin
        logic [11:0] f;
        for (int r = 0; r < 4; r++) f[r*3 +: 3] = 3'((n + r) % 8);
        load_cfg(m[0], f);
        for (int r = 0; r < 4; r++) begin
          for (int w = 0; w < 2; w++) begin
            logic [10:0] a;
            logic [15:0] d;
            a = {r[1:0], 9'(n * 37 + w * 5 + r)};
            d = 16'(n * 4099 + r * 257 + w * 17 + m);
            @(negedge clk);
            start_req(w[0], a, d);
            observe(w[0], a, d, exp_wait(m[0], (n + r) % 8), -1, 0, 0, '0, '0);
          end
        end
      end
    end

    // R8: stray requests during an access (fields 5, 5, 2, 6; normal mode)
    load_cfg(1'b0, {3'd6, 3'd2, 3'd5, 3'd5});
    @(negedge clk);
    start_req(1'b0, 11'h0A3, 16'h1111);
    observe(1'b0, 11'h0A3, 16'h1111, 5, 0, 0, 0, '0, '0);
    @(negedge clk);
    start_req(1'b1, 11'h6F0, 16'h2222);
    observe(1'b1, 11'h6F0, 16'h2222, 6, 4, 0, 0, '0, '0);

    // R9: back-to-back, read then write then read
    @(negedge clk);
    start_req(1'b0, 11'h412, 16'h0);
    observe(1'b0, 11'h412, 16'h0, 2, -1, 1, 1'b1, 11'h213, 16'hBEEF);
    observe(1'b1, 11'h213, 16'hBEEF, 5, -1, 1, 1'b0, 11'h7FF, 16'h0);
    observe(1'b0, 11'h7FF, 16'h0, 6, -1, 0, 0, '0, '0);

    // R11: load during an access; the running access keeps 7 waits
    load_cfg(1'b0, 12'hFFF);
    @(negedge clk);
    start_req(1'b1, 11'h001, 16'h5555);
    fork
      observe(1'b1, 11'h001, 16'h5555, 7, -1, 0, 0, '0, '0);
      begin
        repeat (3) @(negedge clk);
        cfg_load = 1'b1; cfg_mode = 1'b1; cfg_waits = 12'h000;
        @(negedge clk);
        cfg_load = 1'b0;
      end
    join
    @(negedge clk);
    start_req(1'b0, 11'h001, 16'h0);
    observe(1'b0, 11'h001, 16'h0, 1, -1, 0, 0, '0, '0); // R11 new mode: 2*0+1

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule